// File: doc/BRIEF.md
# Two-Byte-Address Serial EEPROM Transfer Sequencer

This block is an I2C bus master that moves a run of bytes to or from a serial EEPROM addressed by a 16-bit word address. A single command carries a direction flag, the word address and a byte count. The block then runs the whole bus transaction by itself. It opens the transfer with a start condition, selects the device, and sends both address bytes, upper byte first. It then either streams the write bytes or performs a repeated start and reads the bytes back.

Write bytes are pulled from the surrounding logic through a ready/valid handshake, one byte per data frame. Read bytes are handed out with a one-cycle valid strobe. Both bus lines are open-drain: an enable output pulls the line low, and releasing it lets the line float high. All bus timing is built from a quarter-bit tick that a parameterised prescaler derives from the system clock.

Top module: `ee_i2c_seq`

## Requirements
- R1: The `status` output encodes 2'b00 as no result since reset, 2'b01 as busy, 2'b10 as success and 2'b11 as failure. It reads busy from the clock edge that accepts a command until the final stop completes. Whenever it is not busy, both `scl_oe` and `sda_oe` are low (lines released).
- R2: Bit timing is four quarter-bit ticks of `QDIV` clocks each. Inside a byte, successive SCL rising edges are exactly 4*`QDIV` clocks apart. A start raises SDA, raises SCL, pulls SDA low and then pulls SCL low. A stop pulls SDA low, releases SCL and then releases SDA, one tick per step.
- R3: A write sends a start, then the device byte `DEV_ADDR` with bit 0 cleared, then the upper and lower word address bytes. The data bytes follow, each most significant bit first. A stop follows the last counted byte, and status then becomes success.
- R4: A read sends a start, the device byte with bit 0 cleared and both address bytes. It then sends a repeated start and the device byte with bit 0 set. Each received byte (MSB first) is presented on `rd_data` with `rd_valid` high for exactly one cycle. Status then becomes success.
- R5: During a read the master pulls SDA low in the ninth clock of every received byte except the last. On the last byte it leaves SDA released, then sends a stop.
- R6: If SDA is high during the ninth clock after any byte the master transmits, the block sends a stop, requests no further write data and ends with failure status.
- R7: A command with a count of zero is answered with failure status on the next cycle. Status is never busy for it, and no start condition occurs.
- R8: A command presented while status is busy is ignored and does not change the running transfer.
- R9: `wr_ready` is high only while the block waits for the next write byte. No data bits are clocked until `wr_valid` is seen with it, and SCL holds still meanwhile.
- R10: A write contains exactly one start and one stop condition. A read contains exactly two starts (initial and repeated) and one stop. Apart from these, SDA changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_rd | input | 1 | 1 = read transfer, 0 = write transfer |
| cmd_addr | input | 16 | EEPROM word address |
| cmd_len | input | LEN_W | Number of data bytes |
| wr_data | input | 8 | Next byte to write |
| wr_valid | input | 1 | `wr_data` holds a byte |
| wr_ready | output | 1 | Sequencer waits for a write byte |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| status | output | 2 | Transfer status code (see R1) |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The hardest situations to reach from the ports are a refusal in the middle of a transfer and the master's own acknowledge pattern on reads. Neither can be seen without a device that answers on SDA. The bench therefore carries a behavioural EEPROM that decodes starts, stops and bytes from the line levels. It can be told to refuse a chosen byte index or to answer to a different device address, so a NACK can be placed on the device byte, on an address byte or on a data byte. The same model counts master ACKs and NACKs and measures SCL spacing. Sweeps over lengths and addresses then compare memory and read data with values computed in the bench.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;

   // primitive bus operations run by the bit engine
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_TX    = 2'd2,
      OP_RX    = 2'd3
   } bus_op_e;

   // externally visible result code
   typedef enum logic [1:0] {
      STS_NONE = 2'd0,
      STS_BUSY = 2'd1,
      STS_OK   = 2'd2,
      STS_ERR  = 2'd3
   } seq_sts_e;

   // transaction phases of the sequencer
   typedef enum logic [3:0] {
      S_IDLE, S_START, S_DEVW, S_AHI, S_ALO, S_WREQ, S_WDATA,
      S_RSTART, S_DEVR, S_RDATA, S_STOP
   } seq_st_e;

endpackage

// File: rtl/ee_i2c_qtick.sv
module ee_i2c_qtick #(
   parameter int QDIV = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (QDIV == 1) begin : g_pass
         assign tick = run;
      end else begin : g_div
         localparam int CW = $clog2(QDIV);
         localparam logic [CW-1:0] LAST = CW'(QDIV - 1);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt <= '0;
            else if (!run)          cnt <= '0;
            else if (cnt == LAST)   cnt <= '0;
            else                    cnt <= cnt + CW'(1);
         end

         assign tick = run && (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/ee_i2c_bitio.sv
module ee_i2c_bitio
   import ee_i2c_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go,
   input  bus_op_e    op,
   input  logic [7:0] tx_byte,
   input  logic       mack,
   input  logic       sda_in,
   output logic       done,
   output logic       ack_ok,
   output logic [7:0] rx_byte,
   output logic       scl_oe,
   output logic       sda_oe
);

   logic       active;
   bus_op_e    op_q;
   logic [1:0] q;
   logic [3:0] bit_i;
   logic [7:0] sh;
   logic       mack_q;
   logic       ack_slot;

   assign ack_slot = bit_i[3];
   assign rx_byte  = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         op_q   <= OP_START;
         q      <= '0;
         bit_i  <= '0;
         sh     <= '0;
         mack_q <= 1'b0;
         done   <= 1'b0;
         ack_ok <= 1'b0;
         scl_oe <= 1'b0;
         sda_oe <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (go) begin
               active <= 1'b1;
               op_q   <= op;
               q      <= '0;
               bit_i  <= '0;
               sh     <= tx_byte;
               mack_q <= mack;
            end
         end else if (tick) begin
            q <= q + 2'd1;
            case (op_q)
               OP_START: begin
                  case (q)
                     2'd0:    sda_oe <= 1'b0;
                     2'd1:    scl_oe <= 1'b0;
                     2'd2:    sda_oe <= 1'b1;
                     default: begin
                        scl_oe <= 1'b1;
                        active <= 1'b0;
                        done   <= 1'b1;
                     end
                  endcase
               end
               OP_STOP: begin
                  case (q)
                     2'd0:    sda_oe <= 1'b1;
                     2'd1:    scl_oe <= 1'b0;
                     2'd2:    sda_oe <= 1'b0;
                     default: begin
                        active <= 1'b0;
                        done   <= 1'b1;
                     end
                  endcase
               end
               default: begin
                  case (q)
                     2'd0: begin
                        if (ack_slot) sda_oe <= (op_q == OP_RX) && mack_q;
                        else          sda_oe <= (op_q == OP_TX) && !sh[7];
                     end
                     2'd1: scl_oe <= 1'b0;
                     2'd2: begin
                        if (ack_slot) ack_ok <= !sda_in;
                        else          sh     <= {sh[6:0], sda_in};
                     end
                     default: begin
                        scl_oe <= 1'b1;
                        if (ack_slot) begin
                           active <= 1'b0;
                           done   <= 1'b1;
                        end else begin
                           bit_i <= bit_i + 4'd1;
                        end
                     end
                  endcase
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/ee_i2c_seq.sv
module ee_i2c_seq
   import ee_i2c_pkg::*;
#(
   parameter int         QDIV     = 125,
   parameter logic [7:0] DEV_ADDR = 8'hA0,
   parameter int         LEN_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_rd,
   input  logic [15:0]      cmd_addr,
   input  logic [LEN_W-1:0] cmd_len,
   input  logic [7:0]       wr_data,
   input  logic             wr_valid,
   output logic             wr_ready,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic [1:0]       status,
   output logic             scl_oe,
   output logic             sda_oe,
   input  logic             sda_in
);

   localparam logic [7:0]       DEV_WR  = {DEV_ADDR[7:1], 1'b0};
   localparam logic [7:0]       DEV_RD  = {DEV_ADDR[7:1], 1'b1};
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] LEN_TWO = LEN_W'(2);

   generate
      if (QDIV < 1) begin : g_bad_qdiv
         $error("QDIV must be at least 1");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("LEN_W must be at least 2");
      end
   endgenerate

   seq_st_e          st;
   seq_sts_e         sts;
   logic             rd_q;
   logic [15:0]      addr_q;
   logic [LEN_W-1:0] left_q;
   logic             ok_q;
   logic             eg_go, eg_mack, eg_done, eg_ack, tick;
   bus_op_e          eg_op;
   logic [7:0]       eg_tx, eg_rx;
   logic             last_byte, tx_phase;

   assign last_byte = (left_q == LEN_ONE);
   assign tx_phase  = (st == S_DEVW) || (st == S_AHI) || (st == S_ALO) ||
                      (st == S_WDATA) || (st == S_DEVR);
   assign wr_ready  = (st == S_WREQ);
   assign status    = sts;

   ee_i2c_qtick #(.QDIV(QDIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(st != S_IDLE), .tick(tick)
   );

   ee_i2c_bitio u_bit (
      .clk(clk), .rst_n(rst_n), .tick(tick), .go(eg_go), .op(eg_op),
      .tx_byte(eg_tx), .mack(eg_mack), .sda_in(sda_in), .done(eg_done),
      .ack_ok(eg_ack), .rx_byte(eg_rx), .scl_oe(scl_oe), .sda_oe(sda_oe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         sts      <= STS_NONE;
         rd_q     <= 1'b0;
         addr_q   <= '0;
         left_q   <= '0;
         ok_q     <= 1'b0;
         eg_go    <= 1'b0;
         eg_op    <= OP_START;
         eg_tx    <= '0;
         eg_mack  <= 1'b0;
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         eg_go    <= 1'b0;
         rd_valid <= 1'b0;
         if (eg_done && tx_phase && !eg_ack) begin
            st    <= S_STOP;
            ok_q  <= 1'b0;
            eg_go <= 1'b1;
            eg_op <= OP_STOP;
         end else begin
            case (st)
               S_IDLE: if (cmd_valid) begin
                  if (cmd_len == '0) begin
                     sts <= STS_ERR;
                  end else begin
                     sts    <= STS_BUSY;
                     rd_q   <= cmd_rd;
                     addr_q <= cmd_addr;
                     left_q <= cmd_len;
                     ok_q   <= 1'b0;
                     st     <= S_START;
                     eg_go  <= 1'b1;
                     eg_op  <= OP_START;
                  end
               end
               S_START: if (eg_done) begin
                  st <= S_DEVW; eg_go <= 1'b1; eg_op <= OP_TX; eg_tx <= DEV_WR;
               end
               S_DEVW: if (eg_done) begin
                  st <= S_AHI; eg_go <= 1'b1; eg_op <= OP_TX; eg_tx <= addr_q[15:8];
               end
               S_AHI: if (eg_done) begin
                  st <= S_ALO; eg_go <= 1'b1; eg_op <= OP_TX; eg_tx <= addr_q[7:0];
               end
               S_ALO: if (eg_done) begin
                  if (rd_q) begin
                     st <= S_RSTART; eg_go <= 1'b1; eg_op <= OP_START;
                  end else begin
                     st <= S_WREQ;
                  end
               end
               S_WREQ: if (wr_valid) begin
                  st <= S_WDATA; eg_go <= 1'b1; eg_op <= OP_TX; eg_tx <= wr_data;
               end
               S_WDATA: if (eg_done) begin
                  if (last_byte) begin
                     ok_q <= 1'b1; st <= S_STOP; eg_go <= 1'b1; eg_op <= OP_STOP;
                  end else begin
                     left_q <= left_q - LEN_ONE;
                     st     <= S_WREQ;
                  end
               end
               S_RSTART: if (eg_done) begin
                  st <= S_DEVR; eg_go <= 1'b1; eg_op <= OP_TX; eg_tx <= DEV_RD;
               end
               S_DEVR: if (eg_done) begin
                  st <= S_RDATA; eg_go <= 1'b1; eg_op <= OP_RX; eg_mack <= !last_byte;
               end
               S_RDATA: if (eg_done) begin
                  rd_data  <= eg_rx;
                  rd_valid <= 1'b1;
                  if (last_byte) begin
                     ok_q <= 1'b1; st <= S_STOP; eg_go <= 1'b1; eg_op <= OP_STOP;
                  end else begin
                     left_q  <= left_q - LEN_ONE;
                     eg_go   <= 1'b1;
                     eg_op   <= OP_RX;
                     eg_mack <= (left_q != LEN_TWO);
                  end
               end
               S_STOP: if (eg_done) begin
                  st  <= S_IDLE;
                  sts <= ok_q ? STS_OK : STS_ERR;
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/ee_i2c_seq_chk.sv
module ee_i2c_seq_chk #(
   parameter int LEN_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [LEN_W-1:0] cmd_len,
   input logic [1:0]       status,
   input logic             scl_oe,
   input logic             sda_oe,
   input logic             rd_valid,
   input logic             wr_ready
);

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'd1) |-> (!scl_oe && !sda_oe)); // R1

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'd1 && cmd_valid && cmd_len != '0) |=> (status == 2'd1)); // R1

   AST_ZERO_LEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (status != 2'd1 && cmd_valid && cmd_len == '0) |=> (status == 2'd3)); // R7

   AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (status == 2'd1 && cmd_valid) |=> (status != 2'd0)); // R8

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R4

   AST_RD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (status == 2'd1)); // R4

   AST_WREADY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> (status == 2'd1)); // R9

   AST_WAIT_SCL_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ready && $past(wr_ready)) |-> $stable(scl_oe)); // R9

endmodule

bind ee_i2c_seq ee_i2c_seq_chk #(.LEN_W(LEN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
   .status(status), .scl_oe(scl_oe), .sda_oe(sda_oe),
   .rd_valid(rd_valid), .wr_ready(wr_ready)
);

// File: tb/ee_i2c_seq_tb_top.sv
module ee_i2c_seq_tb_top;

   localparam int CLK_P = 10;
   localparam int QD    = 3;
   localparam int LW    = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid, cmd_rd, wr_valid;
   logic [15:0]   cmd_addr;
   logic [LW-1:0] cmd_len;
   logic [7:0]    wr_data, rd_data;
   logic          wr_ready, rd_valid, scl_oe, sda_oe;
   logic [1:0]    status;
   logic          slv_pull = 1'b0;
   wire           scl_l  = !scl_oe;
   wire           sda_l  = !(sda_oe || slv_pull);
   wire           sda_in = sda_l;

   always #(CLK_P/2) clk = ~clk;

   ee_i2c_seq #(.QDIV(QD), .DEV_ADDR(8'hA0), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .wr_data(wr_data),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
      .rd_valid(rd_valid), .status(status), .scl_oe(scl_oe),
      .sda_oe(sda_oe), .sda_in(sda_in)
   );

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   always @(posedge clk) cyc++;

   // write source and read sink
   logic [7:0] wbuf [0:15];
   logic [7:0] rbuf [0:15];
   int widx = 0, ridx = 0;
   bit wpend = 0;
   assign wr_data = wbuf[widx[3:0]];

   always @(negedge clk) begin
      if (wpend) begin widx++; wpend = 0; end
      if (wr_ready && wr_valid) wpend = 1;
      if (rd_valid) begin rbuf[ridx[3:0]] = rd_data; ridx++; end
   end

   // behavioural EEPROM on the bus lines
   logic [7:0]  mem [0:255];
   logic [6:0]  slv_id = 7'h50;
   int          nack_idx = -1;
   logic        p_scl = 1'b1, p_sda = 1'b1;
   int          bits = -1, bidx = 0;
   logic [7:0]  sh = '0, ptr = '0;
   logic [15:0] waddr = '0;
   bit          s_tx = 0, go_tx = 0, m_ack = 0, ack = 0;
   int          n_start = 0, n_stop = 0, n_devw = 0, n_devr = 0;
   int          n_mack = 0, n_mnack = 0, n_wr = 0, n_rise = 0;
   int          per_err = 0, last_rise = 0;

   always @(negedge clk) begin
      if (scl_l && p_scl && p_sda && !sda_l) begin
         n_start++; bits = 0; bidx = 0; s_tx = 0; go_tx = 0; slv_pull = 0;
      end else if (scl_l && p_scl && !p_sda && sda_l) begin
         n_stop++; bits = -1; s_tx = 0; go_tx = 0; slv_pull = 0;
      end else if (!p_scl && scl_l && bits >= 0) begin
         if (bits > 0 && bits < 8) begin
            n_rise++;
            if (cyc - last_rise != 4*QD) per_err++;
         end
         last_rise = cyc;
         if (bits < 8) sh = {sh[6:0], sda_l};
         else if (s_tx) m_ack = !sda_l;
         bits++;
      end else if (p_scl && !scl_l && bits >= 0) begin
         if (bits == 8) begin
            if (s_tx) slv_pull = 0;
            else begin
               ack = 1;
               if (bidx == 0) begin
                  if (sh[7:1] != slv_id) ack = 0;
                  else if (sh[0]) begin n_devr++; go_tx = 1; end
                  else n_devw++;
               end else if (bidx == 1) waddr[15:8] = sh;
               else if (bidx == 2) begin waddr[7:0] = sh; ptr = sh; end
               else begin mem[ptr] = sh; ptr++; n_wr++; end
               if (bidx == nack_idx) ack = 0;
               if (!ack) go_tx = 0;
               bidx++;
               slv_pull = ack;
            end
         end else if (bits == 9) begin
            bits = 0; slv_pull = 0;
            if (s_tx) begin
               if (m_ack) begin n_mack++; ptr++; slv_pull = !mem[ptr][7]; end
               else begin n_mnack++; s_tx = 0; bits = -1; end
            end else if (go_tx) begin
               s_tx = 1; go_tx = 0; slv_pull = !mem[ptr][7];
            end
         end else if (s_tx && bits >= 1 && bits <= 7) begin
            slv_pull = !mem[ptr][7-bits];
         end
      end
      p_scl = scl_l; p_sda = sda_l;
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
   endtask

   task automatic issue(bit rd, logic [15:0] a, int len);
      @(negedge clk);
      cmd_valid = 1; cmd_rd = rd; cmd_addr = a; cmd_len = LW'(len);
      @(negedge clk);
      cmd_valid = 0;
      if (len != 0) chk(status == 2'd1, "R1", "busy after accept", status, 1);
   endtask

   task automatic wait_done();
      int t = 0;
      while (status == 2'd1 && t < 20000) begin @(negedge clk); t++; end
      chk(t < 20000, "R1", "transfer completes", t, 0);
   endtask

   task automatic run_cmd(bit rd, logic [15:0] a, int len);
      issue(rd, a, len);
      wait_done();
   endtask

   task automatic do_write(logic [15:0] a, int len);
      int s0 = n_start, p0 = n_stop, w0 = n_devw;
      for (int i = 0; i < len; i++) wbuf[i] = 8'((a[7:0] * 5) + i * 37 + len) ^ 8'h5A;
      widx = 0;
      run_cmd(0, a, len);
      chk(status == 2'd2, "R3", "write status", status, 2);
      for (int i = 0; i < len; i++)
         chk(mem[8'(a[7:0] + i)] == wbuf[i], "R3", "written byte", mem[8'(a[7:0] + i)], wbuf[i]);
      chk(waddr == a, "R3", "word address", waddr, a);
      chk(n_devw - w0 == 1, "R3", "write device byte", n_devw - w0, 1);
      chk(n_start - s0 == 1, "R10", "write starts", n_start - s0, 1);
      chk(n_stop - p0 == 1, "R10", "write stops", n_stop - p0, 1);
      chk(widx == len, "R9", "bytes requested", widx, len);
   endtask

   task automatic do_read(logic [15:0] a, int len);
      int s0 = n_start, p0 = n_stop, w0 = n_devw, r0 = n_devr, k0 = n_mack, q0 = n_mnack;
      ridx = 0;
      run_cmd(1, a, len);
      chk(status == 2'd2, "R4", "read status", status, 2);
      chk(ridx == len, "R4", "read strobes", ridx, len);
      for (int i = 0; i < len; i++)
         chk(rbuf[i] == mem[8'(a[7:0] + i)], "R4", "read byte", rbuf[i], mem[8'(a[7:0] + i)]);
      chk(waddr == a, "R4", "dummy write address", waddr, a);
      chk(n_devw - w0 == 1 && n_devr - r0 == 1, "R4", "device bytes w/r", n_devr - r0, 1);
      chk(n_start - s0 == 2, "R10", "read starts", n_start - s0, 2);
      chk(n_stop - p0 == 1, "R10", "read stops", n_stop - p0, 1);
      chk(n_mack - k0 == len - 1, "R5", "master acks", n_mack - k0, len - 1);
      chk(n_mnack - q0 == 1, "R5", "final nack", n_mnack - q0, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog act=expired exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] addrs [0:2];
      int s0, p0, bad, w0;
      logic [7:0] keep0, keep1;
      addrs[0] = 16'h0000; addrs[1] = 16'h12FE; addrs[2] = 16'hA57C;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 11 + 3);
      for (int i = 0; i < 16; i++) begin wbuf[i] = '0; rbuf[i] = '0; end
      rst_n = 0; cmd_valid = 0; cmd_rd = 0; cmd_addr = '0; cmd_len = '0; wr_valid = 1;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(status == 2'd0, "R1", "reset status", status, 0);
      chk(!scl_oe && !sda_oe, "R1", "reset lines released", {scl_oe, sda_oe}, 0);
      chk(!wr_ready && !rd_valid, "R9", "reset handshakes", {wr_ready, rd_valid}, 0);

      // sweep of addresses and lengths, write then read back
      for (int ai = 0; ai < 3; ai++)
         for (int len = 1; len <= 4; len++) begin
            do_write(addrs[ai], len);
            do_read(addrs[ai], len);
         end

      // longer read from preloaded contents
      for (int i = 0; i < 6; i++) mem[8'(8'h80 + i)] = 8'(i * 53 + 17);
      do_read(16'h3380, 6);

      // R7 zero count
      s0 = n_start;
      issue(0, 16'h0011, 0);
      chk(status == 2'd3, "R7", "zero count error", status, 3);
      repeat (50) @(negedge clk);
      chk(n_start == s0 && !scl_oe && !sda_oe, "R7", "no bus activity", n_start - s0, 0);
      chk(status == 2'd3, "R7", "error held", status, 3);

      // R8 command while busy is ignored
      for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hC3 + i * 19);
      widx = 0; ridx = 0; s0 = n_start;
      issue(0, 16'h0050, 3);
      repeat (100) @(negedge clk);
      cmd_valid = 1; cmd_rd = 1; cmd_addr = 16'h0090; cmd_len = LW'(5);
      @(negedge clk);
      cmd_valid = 0;
      wait_done();
      chk(status == 2'd2, "R8", "original transfer ok", status, 2);
      chk(n_start - s0 == 1 && ridx == 0, "R8", "no second transfer", n_start - s0, 1);
      chk(waddr == 16'h0050, "R8", "address kept", waddr, 16'h0050);
      for (int i = 0; i < 3; i++)
         chk(mem[8'(8'h50 + i)] == wbuf[i], "R8", "data kept", mem[8'(8'h50 + i)], wbuf[i]);

      // R9 stall of write data
      wbuf[0] = 8'h96; wbuf[1] = 8'h3C; widx = 0;
      wr_valid = 0;
      issue(0, 16'h0040, 2);
      bad = 0;
      while (!wr_ready && bad < 5000) begin @(negedge clk); bad++; end
      keep0 = {7'd0, scl_oe};
      bad = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!wr_ready || scl_oe != keep0[0]) bad++;
      end
      chk(bad == 0, "R9", "wait holds ready and SCL", bad, 0);
      chk(widx == 0, "R9", "nothing taken", widx, 0);
      wr_valid = 1;
      wait_done();
      chk(status == 2'd2 && mem[8'h40] == 8'h96 && mem[8'h41] == 8'h3C,
          "R9", "stalled write result", mem[8'h41], 8'h3C);

      // R6 wrong device address
      slv_id = 7'h51; keep0 = mem[8'h20]; keep1 = mem[8'h21];
      wbuf[0] = 8'h01; wbuf[1] = 8'h02; widx = 0; p0 = n_stop;
      run_cmd(0, 16'h0020, 2);
      chk(status == 2'd3, "R6", "device nack error", status, 3);
      chk(widx == 0, "R6", "no data requested", widx, 0);
      chk(mem[8'h20] == keep0 && mem[8'h21] == keep1, "R6", "memory untouched", mem[8'h20], keep0);
      chk(n_stop - p0 == 1, "R6", "stop after nack", n_stop - p0, 1);
      slv_id = 7'h50;

      // R6 refusal of first data byte
      nack_idx = 3; widx = 0; w0 = n_wr; p0 = n_stop;
      wbuf[0] = 8'h77; wbuf[1] = 8'h78; wbuf[2] = 8'h79;
      run_cmd(0, 16'h0030, 3);
      chk(status == 2'd3, "R6", "data nack error", status, 3);
      chk(widx == 1 && n_wr - w0 == 1, "R6", "transfer cut after nack", widx, 1);
      chk(n_stop - p0 == 1, "R6", "stop after data nack", n_stop - p0, 1);

      // R6 refusal of upper address byte in a read
      nack_idx = 1; ridx = 0;
      run_cmd(1, 16'h0060, 2);
      chk(status == 2'd3, "R6", "address nack error", status, 3);
      chk(ridx == 0, "R6", "no read strobes", ridx, 0);
      nack_idx = -1;

      // R2 quarter-bit spacing, R1 lines after the end
      chk(n_rise > 0 && per_err == 0, "R2", "SCL period errors", per_err, 0);
      chk(!scl_oe && !sda_oe, "R1", "lines released at end", {scl_oe, sda_oe}, 0);

      summary();
      $finish;
   end

endmodule